// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block produces the address stream for one DMA channel. Software gives it a base address, a row length with a signed element stride, a row count with a signed row stride, and an element size of 1, 2 or 4 bytes. The block walks each row element by element. After the final element of a row it applies the row stride in place of the element stride. Neither stride is tied to the other, so the row stride may be smaller than the element stride, or negative. Interleaved or de-interleaved streams come from that.

Each address appears on a valid/ready handshake and advances only when it is accepted. A job begins when the channel enable goes from low to high. In one-shot mode the channel stops after the final element and raises a done flag. In circular mode it returns to the base address, reloads both counts and carries on. An interrupt pulse can be raised at the end of every row or only at the end of each full buffer. A one-dimensional transfer is the case of one row.

Top module: `dma2d_addr_gen`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `out_valid`, `done` and `irq` are 0.
- R2: A low-to-high transition of `chan_en` captures the configuration and clears `done`. On the next cycle `out_valid` is 1 and `out_addr` equals `cfg_base`.
- R3: Within a row, each accepted address is followed by the previous address plus the signed `cfg_elem_stride` times the element size. `cfg_esize` codes are: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 4 bytes.
- R4: After the final element of a row that is not the final row, the next address is the current address plus the signed `cfg_row_stride` times the element size. This holds for any magnitude or sign relation between the two strides.
- R5: A count field of 0 stands for 65536, for both the row length and the row count.
- R6: With `cfg_two_d` = 0 the transfer is one row of `cfg_row_len` elements. `cfg_rows` and `cfg_row_stride` have no effect.
- R7: In one-shot mode (`cfg_circular` = 0), acceptance of the final element drops `out_valid` and sets `done` on the next cycle. No further address is offered until the next enable transition.
- R8: In circular mode, acceptance of the final element is followed by `cfg_base` again with both counts reloaded, and `done` stays 0.
- R9: `irq` is high for exactly one cycle after each accepted address that is the final element of a row when `cfg_row_irq` = 1. With `cfg_row_irq` = 0 the same holds only for the final element of the buffer. `irq` is 0 at all other times.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_addr` holds its value and `out_valid` stays 1.
- R11: Driving `chan_en` low drops `out_valid` in the same cycle and halts the walk without setting `done`. The next enable transition restarts at `cfg_base`.
- R12: Address arithmetic wraps modulo 2^AW, so a stride that crosses zero or the top of the space wraps around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Channel enable; a rising transition starts a job |
| cfg_base | input | AW | Base address of the buffer |
| cfg_row_len | input | 16 | Elements per row (0 means 65536) |
| cfg_elem_stride | input | 16 | Signed element stride, in elements |
| cfg_rows | input | 16 | Rows per buffer (0 means 65536) |
| cfg_row_stride | input | 16 | Signed stride after the last element of a row, in elements |
| cfg_esize | input | 2 | Element size code |
| cfg_two_d | input | 1 | 1 = use row count and row stride; 0 = single row |
| cfg_circular | input | 1 | 1 = circular autobuffer; 0 = one-shot |
| cfg_row_irq | input | 1 | 1 = interrupt per row; 0 = per buffer |
| out_addr | output | AW | Current address |
| out_valid | output | 1 | Address is valid |
| out_ready | input | 1 | Consumer accepts the address |
| irq | output | 1 | Completion interrupt pulse |
| done | output | 1 | One-shot job finished |

## Verification
The bench builds the block with AW = 16. With that width, negative strides from a low base and the 65536-element runs produced by a zero count both cross the address boundary, so the modulo wrap is exercised alongside the zero-means-full-range count. Row and buffer completion are observed under both an always-ready consumer and a pseudo-random stalling one, and with a row stride that is smaller than, and opposite in sign to, the element stride.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

  localparam int CNT_W  = 16;
  localparam int REM_W  = CNT_W + 1;
  localparam int STEP_W = 16;
  localparam int WIDE_W = 32;

  typedef enum logic [1:0] {
    ESZ_B1  = 2'd0,
    ESZ_B2  = 2'd1,
    ESZ_B4  = 2'd2,
    ESZ_B4X = 2'd3
  } esize_e;

  typedef struct packed {
    logic circ;
    logic row_irq;
  } mode_t;

  // A zero count field selects the full 2^CNT_W range.
  function automatic logic [REM_W-1:0] eff_count(input logic [CNT_W-1:0] c);
    if (c == '0) return {1'b1, {CNT_W{1'b0}}};
    return {1'b0, c};
  endfunction

  function automatic logic [1:0] esize_shift(input esize_e e);
    case (e)
      ESZ_B1:  return 2'd0;
      ESZ_B2:  return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

  // Signed stride in elements converted to a signed byte increment.
  function automatic logic signed [WIDE_W-1:0] scaled_step(input logic [STEP_W-1:0] s,
                                                          input esize_e e);
    logic signed [WIDE_W-1:0] w;
    w = WIDE_W'($signed(s));
    return w <<< esize_shift(e);
  endfunction

endpackage

// File: rtl/dma2d_loop_ctr.sv
module dma2d_loop_ctr #(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] init_val,
  output logic         at_last
);

  logic [W-1:0] remaining;

  assign at_last = (remaining == W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      remaining <= '0;
    else if (load)   remaining <= init_val;
    else if (step)   remaining <= at_last ? init_val : remaining - W'(1);
  end

  // R5: a loaded count never reaches zero while the channel walks
  p_rem_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> remaining != '0);

endmodule

// File: rtl/dma2d_addr_reg.sv
module dma2d_addr_reg #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          advance,
  input  logic          take_outer,
  input  logic          rewind,
  input  logic          stall,
  input  logic [AW-1:0] inner_inc,
  input  logic [AW-1:0] outer_inc,
  input  logic [AW-1:0] reload_addr,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] addr_next;

  always_comb begin
    addr_next = addr;
    if (load)             addr_next = load_addr;
    else if (advance) begin
      if (rewind)         addr_next = reload_addr;
      else if (take_outer) addr_next = addr + outer_inc;
      else                addr_next = addr + inner_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr <= '0;
    else        addr <= addr_next;
  end

  // R10: a stalled address is held
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(addr));

  // R2: the walk begins at the supplied base
  p_load_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> addr == $past(load_addr));

endmodule

// File: rtl/dma2d_seq.sv
module dma2d_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic chan_en,
  input  logic hs,
  input  logic x_last,
  input  logic y_last,
  input  logic circ,
  input  logic row_irq,
  output logic start,
  output logic run,
  output logic buf_end,
  output logic out_valid,
  output logic done,
  output logic irq
);

  logic en_q;
  logic finish;

  assign start     = chan_en & ~en_q;
  assign buf_end   = x_last & y_last;
  assign finish    = hs & buf_end & ~circ;
  assign out_valid = run & chan_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      run  <= 1'b0;
      done <= 1'b0;
      irq  <= 1'b0;
    end else begin
      en_q <= chan_en;
      irq  <= hs & x_last & (buf_end | row_irq);
      if (!chan_en)    run <= 1'b0;
      else if (start)  run <= 1'b1;
      else if (finish) run <= 1'b0;
      if (start)       done <= 1'b0;
      else if (finish) done <= 1'b1;
    end
  end

  // R9: an interrupt only follows an accepted end-of-row element
  p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(hs && x_last));

  // R7: a finished one-shot channel offers nothing
  p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid);

  // R8: circular walking never reports done
  p_circ_no_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && circ) |-> !done);

endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
  import dma2d_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chan_en,
  input  logic [AW-1:0] cfg_base,
  input  logic [15:0]   cfg_row_len,
  input  logic [15:0]   cfg_elem_stride,
  input  logic [15:0]   cfg_rows,
  input  logic [15:0]   cfg_row_stride,
  input  logic [1:0]    cfg_esize,
  input  logic          cfg_two_d,
  input  logic          cfg_circular,
  input  logic          cfg_row_irq,
  output logic [AW-1:0] out_addr,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          irq,
  output logic          done
);

  localparam int RW     = REM_W;
  localparam int NLOOPS = 2;

  logic start, run, hs, buf_end;
  mode_t mode_q;
  logic [AW-1:0] base_q, inner_inc_q, outer_inc_q;
  logic [AW-1:0] inner_inc_in, outer_inc_in;
  logic [RW-1:0] xinit_in, yinit_in, xinit_q, yinit_q;
  esize_e esz;

  logic [NLOOPS-1:0] ctr_step, ctr_last;
  logic [RW-1:0]     ctr_init [NLOOPS];

  assign hs  = out_valid & out_ready;
  assign esz = esize_e'(cfg_esize);

  always_comb begin
    xinit_in     = eff_count(cfg_row_len);
    yinit_in     = cfg_two_d ? eff_count(cfg_rows) : RW'(1);
    inner_inc_in = AW'(scaled_step(cfg_elem_stride, esz));
    outer_inc_in = cfg_two_d ? AW'(scaled_step(cfg_row_stride, esz)) : inner_inc_in;
  end

  // Configuration snapshot taken on the enable transition.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q      <= '0;
      inner_inc_q <= '0;
      outer_inc_q <= '0;
      xinit_q     <= '0;
      yinit_q     <= '0;
      mode_q      <= '0;
    end else if (start) begin
      base_q      <= cfg_base;
      inner_inc_q <= inner_inc_in;
      outer_inc_q <= outer_inc_in;
      xinit_q     <= xinit_in;
      yinit_q     <= yinit_in;
      mode_q      <= '{circ: cfg_circular, row_irq: cfg_row_irq};
    end
  end

  always_comb begin
    ctr_init[0] = start ? xinit_in : xinit_q;
    ctr_init[1] = start ? yinit_in : yinit_q;
    ctr_step[0] = hs;
    ctr_step[1] = hs & ctr_last[0];
  end

  // Index 0 walks elements within a row, index 1 walks rows.
  for (genvar g = 0; g < NLOOPS; g++) begin : g_loop
    dma2d_loop_ctr #(.W(RW)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (run),
      .load     (start),
      .step     (ctr_step[g]),
      .init_val (ctr_init[g]),
      .at_last  (ctr_last[g])
    );
  end

  dma2d_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .chan_en   (chan_en),
    .hs        (hs),
    .x_last    (ctr_last[0]),
    .y_last    (ctr_last[1]),
    .circ      (mode_q.circ),
    .row_irq   (mode_q.row_irq),
    .start     (start),
    .run       (run),
    .buf_end   (buf_end),
    .out_valid (out_valid),
    .done      (done),
    .irq       (irq)
  );

  dma2d_addr_reg #(.AW(AW)) u_addr (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (start),
    .load_addr   (cfg_base),
    .advance     (hs),
    .take_outer  (ctr_last[0]),
    .rewind      (buf_end),
    .stall       (out_valid & ~out_ready),
    .inner_inc   (inner_inc_q),
    .outer_inc   (outer_inc_q),
    .reload_addr (base_q),
    .addr        (out_addr)
  );

  // R8: the circular wrap returns to the captured base
  p_rewind_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && buf_end && mode_q.circ) |=> out_addr == $past(base_q));

  // R10: a stalled offer is not withdrawn while enabled
  p_valid_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid || !chan_en));

endmodule

// File: tb/test_dma2d_addr_gen.sv
`timescale 1ns/1ps
module test_dma2d_addr_gen;

  localparam int AW    = 16;
  localparam int AMASK = (1 << AW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          en_drv = 1'b0, en_cut = 1'b0;
  logic          chan_en;
  logic [AW-1:0] cfg_base = '0;
  logic [15:0]   cfg_row_len = '0, cfg_elem_stride = '0, cfg_rows = '0, cfg_row_stride = '0;
  logic [1:0]    cfg_esize = '0;
  logic          cfg_two_d = 1'b0, cfg_circular = 1'b0, cfg_row_irq = 1'b0;
  logic [AW-1:0] out_addr;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic          irq, done;

  assign chan_en = en_drv & ~en_cut;

  dma2d_addr_gen #(.AW(AW)) i_dma2d_addr_gen (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en),
    .cfg_base(cfg_base), .cfg_row_len(cfg_row_len), .cfg_elem_stride(cfg_elem_stride),
    .cfg_rows(cfg_rows), .cfg_row_stride(cfg_row_stride), .cfg_esize(cfg_esize),
    .cfg_two_d(cfg_two_d), .cfg_circular(cfg_circular), .cfg_row_irq(cfg_row_irq),
    .out_addr(out_addr), .out_valid(out_valid), .out_ready(out_ready),
    .irq(irq), .done(done)
  );

  int exp_addr_q[$];
  bit exp_irq_q[$];
  int n_checks = 0, n_fail = 0;
  bit stop_when_empty = 0, stop_pend = 0, irq_pend = 0, ready_rand = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // Monitor: pops the scoreboard on every handshake and checks irq timing.
  always begin
    int ea;
    @(negedge clk);
    if (!en_drv) en_cut = 1'b0;
    if (stop_pend) begin en_cut = 1'b1; stop_pend = 0; end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = ready_rand ? lfsr[0] : 1'b1;
    #1;
    if (rst_n) begin
      if (irq_pend || irq) chk(irq == irq_pend, "R9 irq pulse", int'(irq), int'(irq_pend));
      irq_pend = 0;
      if (out_valid && out_ready) begin
        if (exp_addr_q.size() == 0) begin
          chk(1'b0, "R7 R11 unexpected address", int'(out_addr), 0);
        end else begin
          ea = exp_addr_q.pop_front();
          irq_pend = exp_irq_q.pop_front();
          chk(out_addr == ea[AW-1:0], "R2 R3 R4 R5 R6 R8 R12 address", int'(out_addr), ea);
          if (exp_addr_q.size() == 0 && stop_when_empty) stop_pend = 1;
        end
      end
    end
  end

  // Driver: computes the expected stream and runs one job. limit > 0 cuts the
  // enable after that many accepted addresses.
  task automatic job(input int st, input int xc, input int xs, input int yc, input int ys,
                     input int esz, input bit two_d, input bit circ, input bit rowirq,
                     input int limit, input bit rnd);
    int nx, ny, bytes, a, total, x, y;
    nx    = (xc == 0) ? 65536 : xc;
    ny    = two_d ? ((yc == 0) ? 65536 : yc) : 1;
    bytes = (esz == 0) ? 1 : (esz == 1) ? 2 : 4;
    total = (limit > 0) ? limit : nx * ny;
    a = st; x = 0; y = 0;
    for (int k = 0; k < total; k++) begin
      exp_addr_q.push_back(a & AMASK);
      exp_irq_q.push_back((x == nx - 1) && (rowirq || y == ny - 1));
      if (x == nx - 1) begin
        x = 0;
        if (y == ny - 1) begin y = 0; a = st; end
        else begin y++; a = a + ys * bytes; end
      end else begin
        x++; a = a + xs * bytes;
      end
    end
    stop_when_empty = (limit > 0);
    ready_rand      = rnd;
    cfg_base        = AW'(st);
    cfg_row_len     = 16'(xc);
    cfg_elem_stride = 16'(xs);
    cfg_rows        = 16'(yc);
    cfg_row_stride  = 16'(ys);
    cfg_esize       = 2'(esz);
    cfg_two_d       = two_d;
    cfg_circular    = circ;
    cfg_row_irq     = rowirq;
    en_drv = 1'b1;
    @(negedge clk); #1;
    chk(done == 1'b0, "R2 done cleared on enable", int'(done), 0);
    while (exp_addr_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R7 R11 no offer after end", int'(out_valid), 0);
    chk(done == (!circ && limit == 0), "R7 R8 R11 done flag", int'(done),
        int'(!circ && limit == 0));
    cfg_two_d = 1'b1;
    cfg_rows  = 16'd7;
    @(negedge clk);
    en_drv = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0 && done == 1'b0 && irq == 1'b0, "R1 during reset",
        {out_valid, done, irq}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(out_valid == 1'b0 && done == 1'b0 && irq == 1'b0, "R1 after reset",
        {out_valid, done, irq}, 0);
    @(negedge clk);

    // R6: one row; row count and row stride are set but must be ignored
    job(16'h0040, 5, 1, 7, 100, 0, 1'b0, 1'b0, 1'b0, 0, 1'b0);
    // R4: row stride smaller than and opposite to the element stride, stalls
    job(16'h0100, 4, 3, 3, -8, 1, 1'b1, 1'b0, 1'b1, 0, 1'b1);
    // R12: negative strides from a low base wrap below zero
    job(16'h0004, 3, -2, 2, -1, 2, 1'b1, 1'b0, 1'b0, 0, 1'b0);
    // R8: circular with buffer interrupts, 2.5 buffers, then disable
    job(16'hFFF0, 3, 2, 2, 5, 0, 1'b1, 1'b1, 1'b0, 15, 1'b1);
    // R3: size code 3 behaves as 4 bytes, circular with row interrupts
    job(16'h2000, 2, 1, 3, 1, 3, 1'b1, 1'b1, 1'b1, 13, 1'b0);
    // R11: cut a one-shot job short, then rerun it from the base
    job(16'h0300, 4, 1, 3, 2, 1, 1'b1, 1'b0, 1'b0, 5, 1'b1);
    job(16'h0300, 4, 1, 3, 2, 1, 1'b1, 1'b0, 1'b0, 0, 1'b0);
    // R5: zero row length means 65536 elements
    job(16'h8000, 0, 1, 1, 0, 0, 1'b1, 1'b0, 1'b1, 0, 1'b0);
    // R5: zero row count means 65536 rows
    job(16'h0010, 1, 0, 0, -3, 0, 1'b1, 1'b0, 1'b0, 0, 1'b0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired, queue=%0d", exp_addr_q.size());
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule